// File: doc/BRIEF.md
# Hotplug Slot Status Registers

This block keeps the hot-insert and hot-remove request state for 32 slots on each of several buses. Firmware reaches it through a small word-wide register port. The platform side raises requests, and each request names a bus, a slot and whether the slot is being plugged or asked to unplug. A request sets one bit in that bus's insert or remove bitmap and raises an event toward firmware. Firmware picks a bus through a select register. It then reads that bus's bitmaps and acknowledges a removal by writing an eject mask. The block answers each accepted eject with a one-cycle pulse that names the bus and slot for the logic that performs the teardown.

Each bus also has a removable-slot bitmap. It is loaded from a per-bus mask of slots that must never be removed. That load happens at the end of a flush sequence, which runs after hard reset and again whenever a warm-reset strobe arrives. During the flush, every pending remove request is ejected, one slot per cycle and lowest slot first, before the bus's removable bitmap is reloaded. A legacy mode input changes two behaviours: insert bitmaps are no longer cleared by a read, and writes to the select register always load the default bus.

Top module: `hp_slot_regs`

## Requirements
- R1: After hard reset the insert and remove bitmaps are zero, the select register holds 0, `evt_level` is low, and a flush runs on its own. Once `flush_busy` is low, each bus's removable bitmap equals the bitwise inverse of its 32-bit slice of `fixed_mask` (bus b uses bits 32b+31..32b).
- R2: A plug request (`req_unplug`=0) sets bit `req_slot` of bus `req_bus`'s insert bitmap. An unplug request (`req_unplug`=1) sets that bit in the remove bitmap. `evt_pulse` is high for exactly the one cycle after the request is accepted. `evt_level` is high whenever any bus has a nonzero insert or remove bitmap. Requests whose `req_bus` is `NUM_BUS` or higher change nothing.
- R3: A read strobe puts its data on `reg_rdata` in the next cycle, and that value holds until the next read. The word offsets decode as follows: 0x00 is the insert bitmap, 0x04 the remove bitmap, 0x08 reads zero, 0x0C the removable bitmap, 0x10 the select register, and 0x14 through 0x1C read zero.
- R4: In normal mode (`legacy_mode`=0), reading offset 0x00 clears the selected bus's insert bitmap. Reading the remove bitmap never clears it.
- R5: In legacy mode, reading offset 0x00 leaves the insert bitmap intact, and any write to offset 0x10 loads 0 rather than the written data.
- R6: While the select register holds a value of `NUM_BUS` or more, every read returns zero, including a read of offset 0x10.
- R7: An access acts only when `reg_be` is 4'hF and `reg_addr[1:0]` is 0. Any other write changes no state.
- R8: A write to offset 0x08 takes the lowest set bit of `reg_wdata` as the slot. It clears that slot in both bitmaps of the selected bus, and in the next cycle `ej_valid` pulses with `ej_bus` set to the selected bus and `ej_slot` set to that slot.
- R9: An eject write is ignored when its data is zero or when the select register is out of range. In that case there is no pulse and no bitmap changes.
- R10: When a read that clears an insert bitmap and a plug request for the same bus fall in the same cycle, the read returns the old bitmap and the new request bit survives the clear.
- R11: A flush (after hard reset, or one cycle after `flush_req`) visits buses in rising order. On each bus it ejects the pending remove bits one per cycle, lowest slot first, each with an `ej_valid` pulse, then reloads that bus's removable bitmap. `flush_busy` is high throughout.
- R12: Register writes are ignored while `flush_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode | input | 1 | Selects legacy read and select behaviour |
| flush_req | input | 1 | Warm-reset strobe that starts a flush |
| reg_addr | input | 5 | Byte address inside the register window |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 4 | Byte enables, all four required |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| req_valid | input | 1 | Platform request strobe |
| req_bus | input | BUS_W | Bus index of the request |
| req_slot | input | 5 | Slot number of the request |
| req_unplug | input | 1 | 1 for an unplug request, 0 for a plug |
| fixed_mask | input | NUM_BUS*32 | Non-removable slots, 32 bits per bus |
| evt_level | output | 1 | High while any bitmap is nonzero |
| evt_pulse | output | 1 | One-cycle pulse per accepted request |
| ej_valid | output | 1 | Eject pulse |
| ej_bus | output | BUS_W | Bus of the eject |
| ej_slot | output | 5 | Slot of the eject |
| flush_busy | output | 1 | Flush sequence in progress |

## Verification
The assertions take for granted that every input changes away from the rising edge and is held for a full cycle. They also assume that `fixed_mask` stays constant while a flush runs, and that any request bus index fits in `BUS_W` bits. The bench drives every input on the falling edge through tasks that hold each strobe for exactly one cycle. It keeps the mask fixed for the whole run. It moves the select register out of range only inside the scenario that exercises R6 and R9, and it issues a register write during a flush only to check R12.

// File: rtl/hp_slot_regs.sv
module hp_slot_regs #(
  parameter int NUM_BUS     = 4,
  parameter int BUS_W       = 4,
  parameter int SEL_DEFAULT = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   legacy_mode,
  input  logic                   flush_req,
  input  logic [4:0]             reg_addr,
  input  logic                   reg_rd,
  input  logic                   reg_wr,
  input  logic [3:0]             reg_be,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   req_valid,
  input  logic [BUS_W-1:0]       req_bus,
  input  logic [4:0]             req_slot,
  input  logic                   req_unplug,
  input  logic [NUM_BUS*32-1:0]  fixed_mask,
  output logic                   evt_level,
  output logic                   evt_pulse,
  output logic                   ej_valid,
  output logic [BUS_W-1:0]       ej_bus,
  output logic [4:0]             ej_slot,
  output logic                   flush_busy
);
  localparam int IW   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;
  localparam int LAST = NUM_BUS - 1;

  localparam logic [2:0] OFS_INS = 3'd0;
  localparam logic [2:0] OFS_REM = 3'd1;
  localparam logic [2:0] OFS_EJ  = 3'd2;
  localparam logic [2:0] OFS_RMV = 3'd3;
  localparam logic [2:0] OFS_SEL = 3'd4;

  logic [31:0] ins_q [NUM_BUS];
  logic [31:0] rem_q [NUM_BUS];
  logic [31:0] rmv_q [NUM_BUS];
  logic [31:0] ins_d [NUM_BUS];
  logic [31:0] rem_d [NUM_BUS];
  logic [31:0] sel_q;
  logic          fl_act;
  logic [IW-1:0] fl_ix;

  function automatic logic [4:0] low_bit(input logic [31:0] v);
    low_bit = 5'd0;
    for (int i = 31; i >= 0; i--)
      if (v[i]) low_bit = 5'(i);
  endfunction

  wire [2:0]    widx    = reg_addr[4:2];
  wire          full    = (reg_be == 4'hF) && (reg_addr[1:0] == 2'b00);
  wire          rd_hit  = reg_rd && full;
  wire          wr_hit  = reg_wr && full && !fl_act;
  wire          sel_ok  = sel_q < 32'(NUM_BUS);
  wire [IW-1:0] sel_ix  = sel_q[IW-1:0];
  wire          req_ok  = req_valid && (32'(req_bus) < 32'(NUM_BUS));
  wire [IW-1:0] req_ix  = req_bus[IW-1:0];
  wire          wr_ej   = wr_hit && widx == OFS_EJ && sel_ok && |reg_wdata;
  wire [4:0]    ej_bit  = low_bit(reg_wdata);
  wire          rd_clr  = rd_hit && widx == OFS_INS && sel_ok && !legacy_mode;
  wire          fl_hold = fl_act && rem_q[fl_ix] != 32'd0;
  wire [4:0]    fl_bit  = low_bit(rem_q[fl_ix]);
  wire          fl_adv  = fl_act && !fl_hold;

  always_comb begin
    for (int b = 0; b < NUM_BUS; b++) begin
      logic [31:0] clr;
      logic [31:0] set;
      clr = 32'd0;
      if (wr_ej && sel_ix == IW'(b)) clr = 32'd1 << ej_bit;
      if (fl_hold && fl_ix == IW'(b)) clr = 32'd1 << fl_bit;
      set = (req_ok && req_ix == IW'(b)) ? (32'd1 << req_slot) : 32'd0;
      ins_d[b] = (((rd_clr && sel_ix == IW'(b)) ? 32'd0 : ins_q[b]) & ~clr)
                 | (req_unplug ? 32'd0 : set);
      rem_d[b] = (rem_q[b] & ~clr) | (req_unplug ? set : 32'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BUS; b++) begin
        ins_q[b] <= 32'd0;
        rem_q[b] <= 32'd0;
        rmv_q[b] <= '1;
      end
    end else begin
      for (int b = 0; b < NUM_BUS; b++) begin
        ins_q[b] <= ins_d[b];
        rem_q[b] <= rem_d[b];
        if (fl_adv && fl_ix == IW'(b))
          rmv_q[b] <= ~fixed_mask[b*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_act <= 1'b1;
      fl_ix  <= '0;
    end else if (flush_req) begin
      fl_act <= 1'b1;
      fl_ix  <= '0;
    end else if (fl_adv) begin
      if (fl_ix == IW'(LAST)) fl_act <= 1'b0;
      else                    fl_ix  <= fl_ix + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sel_q <= 32'(SEL_DEFAULT);
    else if (wr_hit && widx == OFS_SEL)
      sel_q <= legacy_mode ? 32'(SEL_DEFAULT) : reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= 32'd0;
    end else if (rd_hit) begin
      if (!sel_ok) reg_rdata <= 32'd0;
      else case (widx)
        OFS_INS: reg_rdata <= ins_q[sel_ix];
        OFS_REM: reg_rdata <= rem_q[sel_ix];
        OFS_RMV: reg_rdata <= rmv_q[sel_ix];
        OFS_SEL: reg_rdata <= sel_q;
        default: reg_rdata <= 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ej_valid  <= 1'b0;
      ej_bus    <= '0;
      ej_slot   <= '0;
      evt_pulse <= 1'b0;
    end else begin
      ej_valid  <= wr_ej || fl_hold;
      ej_bus    <= fl_hold ? BUS_W'(fl_ix) : BUS_W'(sel_ix);
      ej_slot   <= fl_hold ? fl_bit : ej_bit;
      evt_pulse <= req_ok;
    end
  end

  always_comb begin
    evt_level = 1'b0;
    for (int b = 0; b < NUM_BUS; b++)
      evt_level = evt_level | (|ins_q[b]) | (|rem_q[b]);
  end

  assign flush_busy = fl_act;

  // R8
  eject_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ej |=> ej_valid
      && ((($past(reg_wdata) >> ej_slot) & 32'd1) == 32'd1)
      && (($past(reg_wdata) & ((32'd1 << ej_slot) - 32'd1)) == 32'd0));

  // R6
  sel_range_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !sel_ok) |=> reg_rdata == 32'd0);

  // R5
  legacy_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && widx == OFS_SEL && legacy_mode) |=> sel_q == 32'(SEL_DEFAULT));

  // R2
  evt_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> $past(req_valid));

  // R2
  evt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |=> evt_level);

  // R11
  ej_bus_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> 32'(ej_bus) < 32'(NUM_BUS));

  // R12
  flush_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_act |=> $stable(sel_q));
endmodule

// File: tb/tb_hp_slot_regs.sv
`timescale 1ns/1ps
module tb_hp_slot_regs;
  localparam int NB = 4;
  localparam int BW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic legacy_mode = 0, flush_req = 0;
  logic [4:0] reg_addr = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [3:0] reg_be = 4'hF;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic req_valid = 0, req_unplug = 0;
  logic [BW-1:0] req_bus = 0;
  logic [4:0] req_slot = 0;
  logic [NB*32-1:0] fixed_mask;
  logic evt_level, evt_pulse, ej_valid, flush_busy;
  logic [BW-1:0] ej_bus;
  logic [4:0] ej_slot;

  int checks = 0, fails = 0;
  int ej_n = 0;
  logic [8:0] ej_log [16];

  always #5 clk = ~clk;

  assign fixed_mask = {32'h0000_00F0, 32'h8000_0000, 32'h0000_0000, 32'h0000_0003};

  hp_slot_regs #(.NUM_BUS(NB), .BUS_W(BW), .SEL_DEFAULT(0)) dut (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .flush_req(flush_req),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_bus(req_bus), .req_slot(req_slot), .req_unplug(req_unplug),
    .fixed_mask(fixed_mask), .evt_level(evt_level), .evt_pulse(evt_pulse),
    .ej_valid(ej_valid), .ej_bus(ej_bus), .ej_slot(ej_slot), .flush_busy(flush_busy));

  always @(negedge clk) begin
    if (rst_n && ej_valid && ej_n < 16) begin
      ej_log[ej_n] = {ej_bus, ej_slot};
      ej_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; reg_be = 4'hF;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic req(input int bus, input int slot, input logic unplug);
    @(negedge clk);
    req_valid = 1; req_bus = BW'(bus); req_slot = 5'(slot); req_unplug = unplug;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_flush();
    for (int i = 0; i < 400 && flush_busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    wait_flush();
    chk("R1 flush done", 32'(flush_busy), 0);
    chk("R1 evt_level", 32'(evt_level), 0);
    rd(5'h10, d); chk("R1 select", d, 0);
    rd(5'h00, d); chk("R1 insert", d, 0);
    rd(5'h04, d); chk("R1 remove", d, 0);
    rd(5'h0C, d); chk("R1 removable bus0", d, 32'hFFFF_FFFC);
    wr(5'h10, 3); rd(5'h0C, d); chk("R1 removable bus3", d, 32'hFFFF_FF0F);
    wr(5'h10, 0);
  endtask

  task automatic t_plug_read();
    logic [31:0] d;
    req(1, 5, 0);
    chk("R2 evt_pulse", 32'(evt_pulse), 1);
    chk("R2 evt_level", 32'(evt_level), 1);
    @(negedge clk);
    chk("R2 evt_pulse one cycle", 32'(evt_pulse), 0);
    wr(5'h10, 1);
    rd(5'h00, d); chk("R2 insert bit", d, 32'h20);
    rd(5'h00, d); chk("R4 insert cleared by read", d, 0);
    chk("R2 evt_level drops", 32'(evt_level), 0);
    req(5, 2, 0);
    chk("R2 bad bus no pulse", 32'(evt_pulse), 0);
    chk("R2 bad bus no level", 32'(evt_level), 0);
  endtask

  task automatic t_remove_eject();
    logic [31:0] d;
    int n0;
    wr(5'h10, 2);
    req(2, 7, 1); req(2, 3, 1);
    rd(5'h04, d); chk("R2 remove bits", d, 32'h88);
    rd(5'h04, d); chk("R4 remove not cleared", d, 32'h88);
    rd(5'h08, d); chk("R3 offset 08 zero", d, 0);
    rd(5'h14, d); chk("R3 offset 14 zero", d, 0);
    rd(5'h1C, d); chk("R3 offset 1C zero", d, 0);
    n0 = ej_n;
    wr(5'h08, 32'h0000_0088);
    @(negedge clk);
    chk("R8 one pulse", ej_n - n0, 1);
    chk("R8 bus/slot", 32'(ej_log[n0]), {23'd0, 4'd2, 5'd3});
    rd(5'h04, d); chk("R8 remove cleared", d, 32'h80);
    n0 = ej_n;
    wr(5'h08, 0);
    @(negedge clk);
    chk("R9 zero data no pulse", ej_n - n0, 0);
    rd(5'h04, d); chk("R9 zero data no change", d, 32'h80);
    wr(5'h08, 32'h80);
    @(negedge clk);
    rd(5'h04, d); chk("R8 remove empty", d, 0);
  endtask

  task automatic t_out_of_range();
    logic [31:0] d;
    int n0;
    wr(5'h10, 0);
    req(0, 9, 1);
    wr(5'h10, NB);
    rd(5'h10, d); chk("R6 select read zero", d, 0);
    rd(5'h0C, d); chk("R6 removable read zero", d, 0);
    n0 = ej_n;
    wr(5'h08, 32'h200);
    @(negedge clk);
    chk("R9 out of range no pulse", ej_n - n0, 0);
    wr(5'h10, 0, 4'h1);
    rd(5'h04, d); chk("R7 partial write ignored", d, 0);
    wr(5'h10, 0);
    rd(5'h04, d); chk("R9 remove kept", d, 32'h200);
    wr(5'h12, 1);
    rd(5'h10, d); chk("R7 misaligned write ignored", d, 0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    wr(5'h10, 1);
    req(1, 5, 0);
    @(negedge clk);
    reg_addr = 5'h00; reg_rd = 1;
    req_valid = 1; req_bus = 1; req_slot = 9; req_unplug = 0;
    @(negedge clk);
    reg_rd = 0; req_valid = 0;
    chk("R10 read returns old", reg_rdata, 32'h20);
    rd(5'h00, d); chk("R10 new bit survives", d, 32'h200);
  endtask

  task automatic t_legacy();
    logic [31:0] d;
    legacy_mode = 1;
    wr(5'h10, 3);
    rd(5'h10, d); chk("R5 select forced to 0", d, 0);
    req(0, 1, 0);
    rd(5'h00, d); chk("R5 insert first read", d, 32'h2);
    rd(5'h00, d); chk("R5 insert not cleared", d, 32'h2);
    legacy_mode = 0;
    rd(5'h00, d); chk("R4 normal read clears", d, 32'h2);
    rd(5'h00, d); chk("R4 insert now zero", d, 0);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    int n0;
    wr(5'h10, 0);
    wr(5'h08, 32'h200);
    req(0, 4, 1); req(0, 2, 1); req(3, 0, 1);
    wr(5'h10, 3);
    n0 = ej_n;
    @(negedge clk); flush_req = 1;
    @(negedge clk); flush_req = 0;
    chk("R11 busy", 32'(flush_busy), 1);
    wr(5'h10, 1);
    wait_flush();
    @(negedge clk);
    chk("R11 pulse count", ej_n - n0, 3);
    chk("R11 first eject", 32'(ej_log[n0]),     {23'd0, 4'd0, 5'd2});
    chk("R11 second eject", 32'(ej_log[n0 + 1]), {23'd0, 4'd0, 5'd4});
    chk("R11 third eject", 32'(ej_log[n0 + 2]), {23'd0, 4'd3, 5'd0});
    rd(5'h10, d); chk("R12 write during flush ignored", d, 3);
    rd(5'h04, d); chk("R11 bus3 remove empty", d, 0);
    rd(5'h0C, d); chk("R11 bus3 removable", d, 32'hFFFF_FF0F);
    wr(5'h10, 2);
    rd(5'h0C, d); chk("R11 bus2 removable", d, 32'h7FFF_FFFF);
    chk("R11 evt_level low", 32'(evt_level), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_plug_read();
    t_remove_eject();
    t_out_of_range();
    t_same_cycle();
    t_legacy();
    t_flush();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule